// File: doc/BRIEF.md
# Snapshot Register File with Autoincrement Pointer

This block is the sixteen-byte register file of a timekeeping core. A host reaches it one byte at a time through four strobes: one opens a transaction, one loads the address pointer, one writes a data byte and one reads a data byte. After every data byte the pointer moves to the next address. After address 0Fh it goes back to 00h.

Addresses 00h to 06h hold the time. The live counters sit outside this block. They arrive on a flat input bus, and a write to one of them leaves the block as a one-hot strobe together with the masked byte. Time reads never come straight from the live counters. They come from a shadow copy, which is captured when a transaction opens and again each time the pointer wraps to 00h. A multibyte read therefore returns one consistent instant while the clock keeps running. Addresses 07h to 0Fh are plain storage inside the block. Every address has a fixed mask of reserved bits, and those bits are forced to zero.

The host side also has a clock-line level input. If that line stays low for too long, the open transaction is dropped. The host then has to open a new transaction before any data strobe is accepted again.

Top module: `snap_regfile`

## Requirements
- R1: After reset, rdata_o is 00h, the pointer is 00h, no transaction is open, time_we_o is zero, and every storage byte at 07h–0Fh reads 00h.
- R2: A start_i pulse opens a transaction and copies the masked live time bytes into the shadow copy at that clock edge.
- R3: While a transaction is open, addr_load_i sets the pointer to addr_i.
- R4: While a transaction is open, each rd_i pulse puts the masked byte at the pointer on rdata_o at the next edge and advances the pointer by one. Addresses 00h–06h read the shadow copy and addresses 07h–0Fh read storage.
- R5: A data byte at address 0Fh moves the pointer to 00h. The same edge recaptures the shadow copy from the live time.
- R6: Time reads return the shadow copy even after the live time has changed.
- R7: A write at time address n (0–6) raises bit n of time_we_o in the same cycle, with time_wdata_o equal to wdata_i AND the mask. The write leaves the shadow copy unchanged.
- R8: A write at address 07h–0Fh stores wdata_i AND the mask, and a later read returns that value.
- R9: The readable-bit masks are: 00h–02h 7Fh, 03h 07h, 04h 3Fh, 05h 9Fh, 06h FFh, 07h–0Dh FFh, 0Eh 9Fh, 0Fh 83h. Reserved bits read as zero, and writing a one to them has no effect.
- R10: While no transaction is open, addr_load_i, wr_i and rd_i change neither the pointer, rdata_o, the storage nor time_we_o.
- R11: If scl_i is low for TIMEOUT_CYC consecutive edges, the transaction closes at the following edge and the pointer keeps its value. Any high cycle on scl_i restarts the count.
- R12: Priority is start_i, then addr_load_i, then wr_i, then rd_i. A strobe that loses in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Host clock-line level, used by the idle timeout |
| start_i | input | 1 | Transaction start strobe |
| addr_load_i | input | 1 | Pointer load strobe |
| addr_i | input | 4 | Address to load |
| wr_i | input | 1 | Write-byte strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read-byte strobe |
| rdata_o | output | 8 | Last byte read |
| live_time_i | input | 56 | Live time bytes, byte n at bits 8n+7:8n |
| time_we_o | output | 7 | One-hot write strobe to live time byte n |
| time_wdata_o | output | 8 | Masked write data for the live time |

## Verification
The assertions check on every cycle that the time write strobe is one-hot, that it fires only for an accepted write, and that it never fires while no transaction is open. They also check that the pointer steps by one and wraps after 0Fh, that it holds still while no transaction is open, that a start opens a transaction, and that an expired timeout closes it. Some properties can only be shown by the bench's scenarios against its reference model: that reads return the captured instant while the live time moves on, that a wrap recaptures the shadow copy, that the reserved-bit masks apply, and that a closed transaction keeps its pointer.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_REGS = 1 << ADDR_W;
  localparam int unsigned NUM_TIME = 7;

  // readable bits per address; zeros are reserved
  function automatic logic [DATA_W-1:0] reg_mask(input logic [ADDR_W-1:0] a);
    case (a)
      4'h0, 4'h1, 4'h2: reg_mask = 8'h7F;
      4'h3:             reg_mask = 8'h07;
      4'h4:             reg_mask = 8'h3F;
      4'h5:             reg_mask = 8'h9F;
      4'hE:             reg_mask = 8'h9F;
      4'hF:             reg_mask = 8'h83;
      default:          reg_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/snap_timeout.sv
module snap_timeout #(
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (scl_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (cnt_q == LIMIT);
endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              expire_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              active_o,
  output logic              wr_go_o,
  output logic              rd_go_o,
  output logic              capture_o
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] ptr_q;
  logic              active_q;
  logic              load_go, step;

  assign load_go   = active_q & ~start_i & addr_load_i;
  assign wr_go_o   = active_q & ~start_i & ~addr_load_i & wr_i;
  assign rd_go_o   = active_q & ~start_i & ~addr_load_i & ~wr_i & rd_i;
  assign step      = wr_go_o | rd_go_o;
  assign capture_o = start_i | (step & (ptr_q == LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      active_q <= 1'b0;
    end else begin
      if (load_go)   ptr_q <= addr_i;
      else if (step) ptr_q <= ptr_q + 1'b1;  // natural wrap at LAST
      if (start_i)       active_q <= 1'b1;
      else if (expire_i) active_q <= 1'b0;
    end
  end

  assign ptr_o    = ptr_q;
  assign active_o = active_q;
endmodule

// File: rtl/snap_store.sv
module snap_store
  import snap_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          ptr_i,
  input  logic                       wr_go_i,
  input  logic                       rd_go_i,
  input  logic                       capture_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NUM_TIME*DATA_W-1:0] live_time_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_TIME-1:0]        time_we_o,
  output logic [DATA_W-1:0]          time_wdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] rdata_q;

  assign wmask = wdata_i & reg_mask(ptr_i);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] IA = ADDR_W'(i);
    if (i < NUM_TIME) begin : g_shadow
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        regs_q[i] <= '0;
        else if (capture_i) regs_q[i] <= live_time_i[i*DATA_W +: DATA_W] & reg_mask(IA);
      end
      assign time_we_o[i] = wr_go_i & (ptr_i == IA);
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        regs_q[i] <= '0;
        else if (wr_go_i && (ptr_i == IA)) regs_q[i] <= wmask;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_go_i) rdata_q <= regs_q[ptr_i];
  end

  assign rdata_o      = rdata_q;
  assign time_wdata_o = wmask;
endmodule

// File: rtl/snap_regfile.sv
module snap_regfile
  import snap_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       scl_i,
  input  logic                       start_i,
  input  logic                       addr_load_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       wr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       rd_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [NUM_TIME*DATA_W-1:0] live_time_i,
  output logic [NUM_TIME-1:0]        time_we_o,
  output logic [DATA_W-1:0]          time_wdata_o
);
  logic [ADDR_W-1:0] ptr;
  logic active, expire, wr_go, rd_go, capture;

  snap_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timeout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (scl_i),
    .expire_o (expire)
  );

  snap_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .addr_load_i (addr_load_i),
    .addr_i      (addr_i),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .expire_i    (expire),
    .ptr_o       (ptr),
    .active_o    (active),
    .wr_go_o     (wr_go),
    .rd_go_o     (rd_go),
    .capture_o   (capture)
  );

  snap_store u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ptr_i        (ptr),
    .wr_go_i      (wr_go),
    .rd_go_i      (rd_go),
    .capture_i    (capture),
    .wdata_i      (wdata_i),
    .live_time_i  (live_time_i),
    .rdata_o      (rdata_o),
    .time_we_o    (time_we_o),
    .time_wdata_o (time_wdata_o)
  );
endmodule

// File: rtl/snap_regfile_chk.sv
module snap_regfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       addr_load_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [6:0] time_we_o,
  input logic [3:0] ptr,
  input logic       active,
  input logic       expire
);
  logic data_step;
  assign data_step = active && !start_i && !addr_load_i && (wr_i || rd_i);

  a_r7_we_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(time_we_o));

  a_r7_we_needs_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_we_o != 7'd0) |-> wr_i);

  a_r10_no_we_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (time_we_o == 7'd0));

  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_step && ptr != 4'hF) |=> (ptr == $past(ptr) + 4'd1));

  a_r5_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_step && ptr == 4'hF) |=> (ptr == 4'h0));

  a_r10_ptr_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !start_i) |=> $stable(ptr));

  a_r2_start_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active);

  a_r11_timeout_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !start_i) |=> !active);
endmodule

bind snap_regfile snap_regfile_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .addr_load_i (addr_load_i),
  .wr_i        (wr_i),
  .rd_i        (rd_i),
  .time_we_o   (time_we_o),
  .ptr         (ptr),
  .active      (active),
  .expire      (expire)
);

// File: tb/snap_regfile_test.sv
`timescale 1ns/1ps
module snap_regfile_test;
  localparam int TO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, start = 1'b0, aload = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [55:0] live_flat;
  logic [6:0] twe;
  logic [7:0] twdata;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  snap_regfile #(.TIMEOUT_CYC(TO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .start_i(start),
    .addr_load_i(aload), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .live_time_i(live_flat),
    .time_we_o(twe), .time_wdata_o(twdata)
  );

  // bench-side live time core
  logic [7:0] live [7];
  logic tick_en = 1'b0, ld_en = 1'b0;
  int ld_idx = 0;
  logic [7:0] ld_val = '0;

  always_comb for (int i = 0; i < 7; i++) live_flat[i*8 +: 8] = live[i];

  always @(posedge clk) begin
    for (int i = 0; i < 7; i++) begin
      if (twe[i]) live[i] <= twdata;
      else if (ld_en && ld_idx == i) live[i] <= ld_val;
      else if (i == 0 && tick_en) live[i] <= live[i] + 8'd1;
    end
  end

  initial for (int i = 0; i < 7; i++) live[i] = 8'h00;

  // R9 mask table
  function automatic logic [7:0] m_mask(input int a);
    case (a)
      0, 1, 2: return 8'h7F;
      3: return 8'h07;
      4: return 8'h3F;
      5: return 8'h9F;
      14: return 8'h9F;
      15: return 8'h83;
      default: return 8'hFF;
    endcase
  endfunction

  // behavioural reference model
  int ptr_m = 0, cnt_m = 0;
  bit act_m = 0;
  logic [7:0] mem_m [16];
  logic [7:0] rdata_m = 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_m = 0; cnt_m = 0; act_m = 0; rdata_m = 8'h00;
      for (int i = 0; i < 16; i++) mem_m[i] = 8'h00;
    end else begin
      bit wgo, rgo, exp_now;
      wgo = act_m && !start && !aload && wr;
      rgo = act_m && !start && !aload && !wr && rd;
      exp_now = (cnt_m == TO);
      if (rgo) rdata_m = mem_m[ptr_m];
      if (wgo && ptr_m >= 7) mem_m[ptr_m] = wdata & m_mask(ptr_m);
      if (start || ((wgo || rgo) && ptr_m == 15))
        for (int k = 0; k < 7; k++) mem_m[k] = live[k] & m_mask(k);
      if (!start && aload && act_m) ptr_m = addr;
      else if (wgo || rgo) ptr_m = (ptr_m + 1) % 16;
      if (start) act_m = 1;
      else if (exp_now) act_m = 0;
      if (scl) cnt_m = 0;
      else if (cnt_m != TO) cnt_m++;
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) if (rst_n) begin
    logic [6:0] we_exp;
    we_exp = '0;
    if (act_m && !start && !aload && wr && ptr_m < 7) we_exp[ptr_m] = 1'b1;
    checks++;
    if (rdata !== rdata_m) begin
      errors++;
      $display("FAIL R4 model rdata: actual %h expected %h", rdata, rdata_m);
    end
    checks++;
    if (twe !== we_exp) begin
      errors++;
      $display("FAIL R7 model time_we: actual %b expected %b", twe, we_exp);
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk); #1;
  endtask

  task automatic do_start();
    start = 1; nxt(); start = 0;
  endtask

  task automatic do_load(input logic [3:0] a);
    aload = 1; addr = a; nxt(); aload = 0;
  endtask

  task automatic do_wr(input logic [7:0] d);
    wr = 1; wdata = d; nxt(); wr = 0;
  endtask

  task automatic do_rd(output logic [7:0] d);
    rd = 1; nxt(); rd = 0; d = rdata;
  endtask

  task automatic set_live(input int i, input logic [7:0] v);
    ld_en = 1; ld_idx = i; ld_val = v; nxt(); ld_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] lv [7];
    lv = '{8'hD9, 8'h45, 8'hA3, 8'hFE, 8'hC7, 8'h92, 8'h99};
    #1;
    nxt(); nxt();
    check("R1 reset rdata", rdata, 8'h00);
    check("R1 reset time_we", {1'b0, twe}, 8'h00);
    rst_n = 1; nxt();

    // R2/R6: capture at start, live keeps ticking
    for (int i = 0; i < 7; i++) set_live(i, lv[i]);
    tick_en = 1;
    do_start();
    do_load(4'h0);
    for (int i = 0; i < 7; i++) begin
      do_rd(d);
      check($sformatf("R6 snapshot byte %0d", i), d, lv[i] & m_mask(i));
    end
    do_rd(d);
    check("R1 storage reset at 07h", d, 8'h00);

    // R8/R9: storage write with reserved bits
    do_load(4'h7);
    for (int i = 7; i < 16; i++) do_wr(8'hFF);
    do_load(4'h7);
    for (int i = 7; i < 16; i++) begin
      do_rd(d);
      check($sformatf("R9 mask at %0d", i), d, m_mask(i));
    end
    check("R8 last stored 0Fh", d, 8'h83);

    // R7: time write goes to live, shadow untouched
    tick_en = 0;
    set_live(0, 8'h10);
    do_start();
    do_load(4'h2);
    wr = 1; wdata = 8'hFF; #0.5;
    check("R7 we strobe", {1'b0, twe}, 8'h04);
    check("R7 masked wdata", twdata, 8'h7F);
    nxt(); wr = 0;
    do_load(4'h2);
    do_rd(d);
    check("R7 shadow unchanged", d, 8'h23);

    // R6: live moved, shadow holds; R5: wrap recaptures
    set_live(0, 8'h33);
    do_load(4'h0);
    do_rd(d);
    check("R6 shadow holds", d, 8'h10);
    do_load(4'hF);
    do_rd(d);
    check("R4 read 0Fh", d, 8'h83);
    do_rd(d);
    check("R5 wrap recapture byte0", d, 8'h33);
    do_rd(d);
    check("R5 wrap recapture byte1", d, 8'h45);
    do_rd(d);
    check("R2 live written byte2", d, 8'h7F);

    // R3 / R11 / R10: timeout closes, strobes ignored, pointer kept
    do_load(4'h5);
    scl = 0; repeat (TO + 4) nxt(); scl = 1;
    do_rd(d); do_rd(d);
    check("R10 rdata held while idle", d, 8'h7F);
    do_load(4'hC);
    do_wr(8'h11);
    do_start();
    do_rd(d);
    check("R11 pointer kept after timeout", d, 8'h92);
    do_load(4'hC);
    do_rd(d);
    check("R10 idle write ignored", d, 8'hFF);

    // R11: short lows do not accumulate
    scl = 0; repeat (TO - 4) nxt(); scl = 1; nxt();
    scl = 0; repeat (TO - 4) nxt(); scl = 1; nxt();
    do_load(4'h3);
    do_rd(d);
    check("R11 still open after short lows", d, 8'h06);

    // R12: priority
    do_load(4'h4);
    start = 1; rd = 1; nxt(); start = 0; rd = 0;
    check("R12 start beats rd", rdata, 8'h06);
    do_rd(d);
    check("R12 pointer unmoved", d, 8'h07);
    do_load(4'h8);
    wr = 1; rd = 1; wdata = 8'h5A; nxt(); wr = 0; rd = 0;
    check("R12 wr beats rd", rdata, 8'h07);
    aload = 1; addr = 4'h8; wr = 1; wdata = 8'hEE; nxt(); aload = 0; wr = 0;
    do_rd(d);
    check("R3 load beats wr", d, 8'h5A);

    nxt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule